// File: doc/BRIEF.md
# Line Blanking Generator with Horizontal Clock Gating

This block produces one blanking interval per video line and uses it to freeze the horizontal clocks of an image-sensor readout. A pixel counter restarts on every line sync pulse. The blanking output goes high when the counter reaches a programmed start position and falls when it reaches a programmed stop position. Both positions are counted in pixels from the line sync.

The horizontal clock phases are free-running and arrive as two pairs, A and B. Outside the blanking interval they pass through unchanged. During blanking, every phase of pair A is held at one programmed level, and every phase of pair B is held at a second level that is programmed on its own. The blanking state is a register clocked by the pixel clock, so it can only change on a pixel clock edge. A start position that is not less than the stop position turns blanking off for the line.

Top module: `hblank_gate`

## Requirements
- R1: The pixel clock edge that samples `lineSync` high sets the pixel position to 0, and each later edge adds 1. `blankOut` rises at the edge that makes the position equal to `togStart`, provided `togStart < togStop`.
- R2: `blankOut` falls at the edge that makes the position equal to `togStop`. Blanking therefore covers positions `togStart` through `togStop-1`.
- R3: If `togStart >= togStop`, `blankOut` stays low for the whole line.
- R4: While `blankOut` is high, both bits of `hClkAOut` equal `levelA`.
- R5: While `blankOut` is high, both bits of `hClkBOut` equal `levelB`, whatever the value of `levelA`.
- R6: While `blankOut` is low, `hClkAOut` equals `hClkAIn` and `hClkBOut` equals `hClkBIn`.
- R7: After reset, `blankOut` stays low until the first `lineSync`.
- R8: A `lineSync` that arrives during blanking starts a new line at position 0. Blanking then follows the new line's positions: it ends unless `togStart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineSync | input | 1 | Line sync, active high, one cycle wide |
| togStart | input | 13 | Pixel position where blanking starts |
| togStop | input | 13 | Pixel position where blanking stops |
| levelA | input | 1 | Level that pair A is held at during blanking |
| levelB | input | 1 | Level that pair B is held at during blanking |
| hClkAIn | input | 2 | Free-running clock phases of pair A |
| hClkBIn | input | 2 | Free-running clock phases of pair B |
| blankOut | output | 1 | Blanking interval flag |
| hClkAOut | output | 2 | Gated clock phases of pair A |
| hClkBOut | output | 2 | Gated clock phases of pair B |

## Verification
The tests use a mid-line window, a window that starts at position 0, and start positions equal to or greater than the stop position. Together they separate an off-by-one error at either window edge from a missing validity check. The hold levels are tried with pair A low and pair B high, and then the other way round, so that swapped or shared level wiring shows up. The input phases change every cycle, so a stuck output or a missing pass-through cannot go unnoticed. A line that is cut short by a sync during blanking shows whether the counter restart also clears the blanking state.

// File: rtl/hblank_pkg.sv
package hblank_pkg;
  // Strobes from the control module to the gating datapath
  typedef struct packed {
    logic enter;  // blanking starts at this edge
    logic leave;  // blanking ends at this edge (enter has priority)
  } hbStrobe_t;
endpackage

// File: rtl/hblank_ctrl.sv
module hblank_ctrl
  import hblank_pkg::*;
#(
  parameter int POS_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineSync,
  input  logic [POS_W-1:0] togStart,
  input  logic [POS_W-1:0] togStop,
  output hbStrobe_t        strobe
);
  localparam logic [POS_W-1:0] CNT_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pixCnt;
  logic [POS_W-1:0] nextCnt;
  logic             cfgValid;

  always_comb begin
    if (lineSync)               nextCnt = '0;
    else if (pixCnt == CNT_MAX) nextCnt = pixCnt;
    else                        nextCnt = pixCnt + 1'b1;
  end

  // Counter saturates at its maximum, so no blanking happens before the first sync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixCnt <= CNT_MAX;
    else       pixCnt <= nextCnt;
  end

  assign cfgValid     = togStart < togStop;
  assign strobe.enter = cfgValid && (nextCnt == togStart);
  assign strobe.leave = lineSync || !cfgValid || (nextCnt == togStop);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    lineSync |=> pixCnt == '0); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!lineSync && pixCnt != CNT_MAX) |=> pixCnt == $past(pixCnt) + 1'b1); // R1
endmodule

// File: rtl/hblank_datapath.sv
module hblank_datapath
  import hblank_pkg::*;
#(
  parameter int PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbStrobe_t         strobe,
  input  logic              levelA,
  input  logic              levelB,
  input  logic [PAIR_W-1:0] hClkAIn,
  input  logic [PAIR_W-1:0] hClkBIn,
  output logic              blankQ,
  output logic [PAIR_W-1:0] hClkAOut,
  output logic [PAIR_W-1:0] hClkBOut
);
  // Blanking state changes only on a pixel clock edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             blankQ <= 1'b0;
    else if (strobe.enter) blankQ <= 1'b1;
    else if (strobe.leave) blankQ <= 1'b0;
  end

  for (genvar g = 0; g < PAIR_W; g++) begin : g_gate
    assign hClkAOut[g] = blankQ ? levelA : hClkAIn[g];
    assign hClkBOut[g] = blankQ ? levelB : hClkBIn[g];
  end

  AST_ENTER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> blankQ); // R1
  AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.leave && !strobe.enter) |=> !blankQ); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.enter && !strobe.leave) |=> $stable(blankQ)); // R2
endmodule

// File: rtl/hblank_gate.sv
module hblank_gate
  import hblank_pkg::*;
#(
  parameter int POS_W  = 13,
  parameter int PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineSync,
  input  logic [POS_W-1:0]  togStart,
  input  logic [POS_W-1:0]  togStop,
  input  logic              levelA,
  input  logic              levelB,
  input  logic [PAIR_W-1:0] hClkAIn,
  input  logic [PAIR_W-1:0] hClkBIn,
  output logic              blankOut,
  output logic [PAIR_W-1:0] hClkAOut,
  output logic [PAIR_W-1:0] hClkBOut
);
  hbStrobe_t strobe;

  hblank_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineSync(lineSync),
    .togStart(togStart), .togStop(togStop), .strobe(strobe)
  );

  hblank_datapath #(.PAIR_W(PAIR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .levelA(levelA), .levelB(levelB),
    .hClkAIn(hClkAIn), .hClkBIn(hClkBIn),
    .blankQ(blankOut), .hClkAOut(hClkAOut), .hClkBOut(hClkBOut)
  );

  AST_BAD_CFG_NO_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (togStart >= togStop) |=> !blankOut); // R3
endmodule

// File: tb/hblank_gate_tb.sv
module hblank_gate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineSync = 1'b0;
  logic [12:0] togStart = '0;
  logic [12:0] togStop = '0;
  logic        levelA = 1'b0;
  logic        levelB = 1'b0;
  logic [1:0]  hClkAIn = '0;
  logic [1:0]  hClkBIn = '0;
  logic        blankOut;
  logic [1:0]  hClkAOut;
  logic [1:0]  hClkBOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hblank_gate u_dut (
    .clk(clk), .rstN(rstN), .lineSync(lineSync),
    .togStart(togStart), .togStop(togStop),
    .levelA(levelA), .levelB(levelB),
    .hClkAIn(hClkAIn), .hClkBIn(hClkBIn),
    .blankOut(blankOut), .hClkAOut(hClkAOut), .hClkBOut(hClkBOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Checks one pixel position against the expected blanking window and gating
  task automatic checkPixel(int pos, int st, int sp, string tag);
    logic expBlank;
    logic [1:0] expA, expB;
    expBlank = (st < sp) && (pos >= st) && (pos < sp);
    expA = expBlank ? {2{levelA}} : hClkAIn;
    expB = expBlank ? {2{levelB}} : hClkBIn;
    check({tag, " blank"}, {7'd0, blankOut}, {7'd0, expBlank});
    check(expBlank ? "R4 pairA" : "R6 pairA", {6'd0, hClkAOut}, {6'd0, expA});
    check(expBlank ? "R5 pairB" : "R6 pairB", {6'd0, hClkBOut}, {6'd0, expB});
  endtask

  // Runs one line: sync pulse, then len pixels checked
  task automatic runLine(int st, int sp, int len, string tag);
    togStart = 13'(st);
    togStop  = 13'(sp);
    @(negedge clk) lineSync = 1'b1;
    @(negedge clk) lineSync = 1'b0;
    for (int i = 0; i < len; i++) begin
      hClkAIn = 2'(i);
      hClkBIn = ~2'(i + 1);
      #1 checkPixel(i, st, sp, tag);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    levelA = 1'b1; levelB = 1'b1;
    togStart = 13'd0; togStop = 13'd5;
    for (int i = 0; i < 8; i++) begin
      hClkAIn = 2'(i); hClkBIn = 2'(i + 2);
      #1;
      check("R7 blank before sync", {7'd0, blankOut}, 8'd0);
      check("R6 pairA before sync", {6'd0, hClkAOut}, {6'd0, hClkAIn});
      check("R6 pairB before sync", {6'd0, hClkBOut}, {6'd0, hClkBIn});
      @(negedge clk);
    end
  endtask

  task automatic testWindow();
    levelA = 1'b0; levelB = 1'b1;
    runLine(10, 20, 30, "R1 R2 mid window");
    levelA = 1'b1; levelB = 1'b0;
    runLine(3, 4, 8, "R1 R2 single pixel");
  endtask

  task automatic testZeroStart();
    levelA = 1'b1; levelB = 1'b1;
    runLine(0, 6, 10, "R1 start zero");
  endtask

  task automatic testBadCfg();
    levelA = 1'b0; levelB = 1'b0;
    runLine(7, 7, 12, "R3 equal");
    runLine(9, 4, 12, "R3 reversed");
  endtask

  task automatic testResync();
    levelA = 1'b0; levelB = 1'b1;
    runLine(2, 50, 10, "R8 cut line");
    runLine(4, 8, 12, "R8 after resync");
    runLine(0, 40, 5, "R8 cut line zero");
    runLine(0, 3, 6, "R8 resync keeps start zero");
  endtask

  initial begin
    testReset();
    testWindow();
    testZeroStart();
    testBadCfg();
    testResync();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule